// File: doc/BRIEF.md
# DMA Channel Command/Status Controller

This block holds the byte-wide command/status register of a single DMA channel and runs a small transfer sequencer from it. Software writes the register through a plain strobe/data port: one bit gates the channel, and three write-one strobes start a transfer, abort it, or clear the channel's interrupt. Software reads back the gate bit and a done flag. When a transfer starts, the block latches a beat count from `xfer_len`. It then offers one beat per cycle to a data mover through a valid/ready pair. When the count runs out or an abort finishes, it raises a sticky interrupt.

The sequencer has three states. `ST_IDLE` means no transfer is outstanding, and the done flag reads 1. `ST_RUN` means beats are offered. `ST_PAUSE` means a transfer is held because its gate was dropped. The transitions are named as follows:
- *launch*: `ST_IDLE` to `ST_RUN`, on an accepted start with a non-zero length.
- *instant finish*: stays in `ST_IDLE` and raises the interrupt, on an accepted start with a zero length.
- *hold*: `ST_RUN` to `ST_PAUSE`, when the gate is cleared.
- *resume*: `ST_PAUSE` to `ST_RUN`, when the gate is set again.
- *drain*: `ST_RUN` to `ST_IDLE`, on the last handshake.
- *kill*: `ST_RUN` or `ST_PAUSE` to `ST_IDLE`, on an abort written with the gate cleared.

A two-channel system places two copies of this block.

Top module: `dma_chan_ctl`

## Requirements
- R1: During and after reset the register reads 8'h10: done=1 in bit 4, with the gate bit and all other bits 0. `beat_valid` and `irq` are 0.
- R2: Bit 0 is the gate. It is written from `reg_wdata[0]` on every write and reads back in bit 0. Bits 7:5 and bits 3:1 always read 0, whatever was written.
- R3: A write with bit 1 set starts a transfer only if the gate is 1 after that write and done is 1. After that write's edge, done reads 0, `beat_valid` is 1, and the count equals `xfer_len`.
- R4: While running, each cycle with `beat_valid` and `beat_ready` both 1 consumes one beat. After exactly `xfer_len` beats, done reads 1 and `beat_valid` drops.
- R5: Clearing the gate mid-transfer drops `beat_valid` after that write's edge and keeps the remaining count. Setting the gate again resumes, and the total number of beats still equals the length.
- R6: A write with bit 2 set and bit 0 clear ends an outstanding transfer: done reads 1 and `irq` rises. With bit 0 set in that write, or with no transfer outstanding, the abort has no effect.
- R7: `irq` rises whenever a transfer completes or is aborted, and it stays set until a write with bit 3 set. If a completion and a clear fall on the same edge, the completion wins.
- R8: A start written while a transfer is outstanding is ignored. The running count is neither reloaded nor extended.
- R9: A start written while the gate ends up 0 is dropped. Setting the gate later does not launch it.
- R10: An accepted start with `xfer_len` = 0 produces no beat, leaves done at 1, and raises `irq`.
- R11: A single write that sets bit 0 and bit 1 together is accepted as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| xfer_len | input | LEN_W | Beat count sampled when a start is accepted |
| beat_ready | input | 1 | Data mover accepts the offered beat |
| beat_valid | output | 1 | A beat is offered this cycle |
| irq | output | 1 | Sticky channel interrupt |

## Verification
Every result lands one edge after its stimulus. A write or handshake presented in cycle k shows up in `reg_rdata`, `beat_valid` and `irq` just after the edge that closes cycle k, because these outputs are decoded straight from registers. The bench therefore drives inputs on a falling edge and samples on the next falling edge, half a period after the rising edge that consumed them. Handshakes are counted from the values seen in the cycle they were offered. In the table, beat readiness is withheld during any write that pauses or aborts, so each expected value belongs to exactly one edge.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } xfer_state_e;

    localparam int CSR_W     = 8;
    localparam int BIT_GATE  = 0;
    localparam int BIT_START = 1;
    localparam int BIT_ABORT = 2;
    localparam int BIT_ICLR  = 3;
    localparam int BIT_DONE  = 4;

    // decoded command of the current cycle
    typedef struct packed {
        logic gate;   // gate value in force after this cycle's write
        logic start;
        logic abort;
        logic iclr;
    } csr_cmd_t;

endpackage

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
    import dma_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CSR_W-1:0] wdata,
    input  logic             done,
    input  logic             finish,
    output csr_cmd_t         cmd,
    output logic             gate_q,
    output logic             irq,
    output logic [CSR_W-1:0] rdata
);

    always_comb begin
        cmd.gate  = we ? wdata[BIT_GATE] : gate_q;
        cmd.start = we & wdata[BIT_START];
        cmd.abort = we & wdata[BIT_ABORT];
        cmd.iclr  = we & wdata[BIT_ICLR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= cmd.gate;
        end
    end

    // completion has priority over a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (finish) begin
            irq <= 1'b1;
        end else if (cmd.iclr) begin
            irq <= 1'b0;
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[BIT_GATE] = gate_q;
        rdata[BIT_DONE] = done;
    end

    p_irq_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cmd.iclr) |=> irq);

    p_irq_clear_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.iclr && !finish) |=> !irq);

    p_reserved_zero_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[7:5] == 3'b000) && (rdata[3:1] == 3'b000));

endmodule

// File: rtl/dma_beat_counter.sv
module dma_beat_counter #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);

    p_count_held_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt));

    p_no_underflow_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt != '0));

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
    import dma_csr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  csr_cmd_t cmd,
    input  logic     len_zero,
    input  logic     last,
    input  logic     beat_ready,
    output logic     load,
    output logic     dec,
    output logic     finish,
    output logic     beat_valid,
    output logic     done
);

    xfer_state_e state, nxt;

    logic kill;
    logic accept;

    assign kill   = cmd.abort && !cmd.gate;
    assign accept = cmd.start && cmd.gate;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && !len_zero) nxt = ST_RUN;        // launch
            end
            ST_RUN: begin
                if (kill)                    nxt = ST_IDLE;   // kill
                else if (beat_ready && last) nxt = ST_IDLE;   // drain
                else if (!cmd.gate)          nxt = ST_PAUSE;  // hold
            end
            ST_PAUSE: begin
                if (kill)          nxt = ST_IDLE;             // kill
                else if (cmd.gate) nxt = ST_RUN;              // resume
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load       = 1'b0;
        dec        = 1'b0;
        finish     = 1'b0;
        beat_valid = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                done   = 1'b1;
                load   = accept && !len_zero;
                finish = accept && len_zero;          // instant finish
            end
            ST_RUN: begin
                beat_valid = 1'b1;
                dec        = beat_ready && !kill;
                finish     = kill || (beat_ready && last);
            end
            ST_PAUSE: begin
                finish = kill;
            end
            default: begin
                done = 1'b1;
            end
        endcase
    end

    p_kill_ends_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (!done && kill) |=> (done && !beat_valid));

    p_no_start_when_busy_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !load);

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_csr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             beat_ready,
    output logic             beat_valid,
    output logic             irq
);

    csr_cmd_t cmd;
    logic     gate_q;
    logic     done;
    logic     finish;
    logic     load;
    logic     dec;
    logic     last;
    logic     len_zero;

    assign len_zero = (xfer_len == '0);

    dma_csr_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .done   (done),
        .finish (finish),
        .cmd    (cmd),
        .gate_q (gate_q),
        .irq    (irq),
        .rdata  (reg_rdata)
    );

    dma_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .len_zero   (len_zero),
        .last       (last),
        .beat_ready (beat_ready),
        .load       (load),
        .dec        (dec),
        .finish     (finish),
        .beat_valid (beat_valid),
        .done       (done)
    );

    dma_beat_counter #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (xfer_len),
        .dec      (dec),
        .last     (last)
    );

    p_valid_needs_gate_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> gate_q);

    p_launch_needs_gate_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> gate_q);

    p_done_raises_irq_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> irq);

endmodule

// File: tb/test_dma_chan_ctl.sv
module test_dma_chan_ctl;

    localparam int LEN_W = 16;
    localparam int NV    = 25;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             beat_ready = 1'b0;
    logic             beat_valid;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dma_chan_ctl #(.LEN_W(LEN_W)) i_dma_chan_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xfer_len   (xfer_len),
        .beat_ready (beat_ready),
        .beat_valid (beat_valid),
        .irq        (irq)
    );

    // {we, wdata, len, ready, exp_rdata, exp_valid, exp_irq}
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 8'h01, 8'd0, 1'b0, 8'h11, 1'b0, 1'b0},  // 0  R2 gate on
        {1'b1, 8'h03, 8'd3, 1'b0, 8'h01, 1'b1, 1'b0},  // 1  R11 gate+start
        {1'b0, 8'h00, 8'd3, 1'b1, 8'h01, 1'b1, 1'b0},  // 2  R4 beat 1
        {1'b1, 8'h00, 8'd3, 1'b0, 8'h00, 1'b0, 1'b0},  // 3  R5 hold
        {1'b0, 8'h00, 8'd3, 1'b1, 8'h00, 1'b0, 1'b0},  // 4  R5 paused
        {1'b1, 8'h01, 8'd3, 1'b0, 8'h01, 1'b1, 1'b0},  // 5  R5 resume
        {1'b0, 8'h00, 8'd3, 1'b1, 8'h01, 1'b1, 1'b0},  // 6  R4 beat 2
        {1'b0, 8'h00, 8'd3, 1'b1, 8'h11, 1'b0, 1'b1},  // 7  R4 beat 3 done
        {1'b1, 8'h09, 8'd0, 1'b0, 8'h11, 1'b0, 1'b0},  // 8  R7 clear
        {1'b1, 8'h03, 8'd2, 1'b0, 8'h01, 1'b1, 1'b0},  // 9  R3 start len 2
        {1'b1, 8'h03, 8'd5, 1'b1, 8'h01, 1'b1, 1'b0},  // 10 R8 restart ignored
        {1'b0, 8'h00, 8'd5, 1'b1, 8'h11, 1'b0, 1'b1},  // 11 R8 ends after 2
        {1'b1, 8'h0B, 8'd4, 1'b0, 8'h01, 1'b1, 1'b0},  // 12 R3 start+clear
        {1'b1, 8'h05, 8'd4, 1'b0, 8'h01, 1'b1, 1'b0},  // 13 R6 abort gated on
        {1'b1, 8'h04, 8'd4, 1'b0, 8'h10, 1'b0, 1'b1},  // 14 R6 abort
        {1'b1, 8'h08, 8'd4, 1'b0, 8'h10, 1'b0, 1'b0},  // 15 R7 clear
        {1'b1, 8'h02, 8'd3, 1'b0, 8'h10, 1'b0, 1'b0},  // 16 R9 start gate off
        {1'b1, 8'h01, 8'd3, 1'b0, 8'h11, 1'b0, 1'b0},  // 17 R9 not queued
        {1'b1, 8'h03, 8'd0, 1'b0, 8'h11, 1'b0, 1'b1},  // 18 R10 zero length
        {1'b1, 8'h08, 8'd0, 1'b0, 8'h10, 1'b0, 1'b0},  // 19 R7 clear
        {1'b1, 8'h03, 8'd1, 1'b0, 8'h01, 1'b1, 1'b0},  // 20 R3 start len 1
        {1'b1, 8'h09, 8'd1, 1'b1, 8'h11, 1'b0, 1'b1},  // 21 R7 set beats clear
        {1'b1, 8'hE1, 8'd1, 1'b0, 8'h11, 1'b0, 1'b1},  // 22 R2 reserved
        {1'b1, 8'h08, 8'd1, 1'b0, 8'h10, 1'b0, 1'b0},  // 23 R7 clear
        {1'b1, 8'h04, 8'd1, 1'b0, 8'h10, 1'b0, 1'b0}   // 24 R6 idle abort
    };

    function automatic string tag_of(int i);
        case (i)
            0, 22:             return "R2";
            1:                 return "R11";
            2, 6, 7:           return "R4";
            3, 4, 5:           return "R5";
            9, 12, 20:         return "R3";
            10, 11:            return "R8";
            13, 14, 24:        return "R6";
            16, 17:            return "R9";
            18:                return "R10";
            default:           return "R7";
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic we, logic [7:0] wd, int len, logic rdy);
        reg_we     = we;
        reg_wdata  = wd;
        xfer_len   = LEN_W'(len);
        beat_ready = rdy;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", reg_rdata, 8'h10, "rdata in reset");
        check("R1", beat_valid, 0, "valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", reg_rdata, 8'h10, "rdata after reset");
        check("R1", irq, 0, "irq after reset");

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][27], VEC[i][26:19], int'(VEC[i][18:11]), VEC[i][10]);
            @(negedge clk);
            check(tag_of(i), reg_rdata, VEC[i][9:2], $sformatf("rdata v%0d", i));
            check(tag_of(i), beat_valid, VEC[i][1], $sformatf("valid v%0d", i));
            check(tag_of(i), irq, VEC[i][0], $sformatf("irq v%0d", i));
        end

        // R4: long transfer with ready toggling, count handshakes
        begin
            int beats = 0;
            int guard = 0;
            drive(1'b1, 8'h09, 0, 1'b0);
            @(negedge clk);
            drive(1'b1, 8'h03, 40, 1'b0);
            @(negedge clk);
            drive(1'b0, 8'h00, 40, 1'b0);
            while (reg_rdata[4] == 1'b0 && guard < 400) begin
                beat_ready = guard[0];
                if (beat_valid && beat_ready) beats++;
                guard++;
                @(negedge clk);
            end
            beat_ready = 1'b0;
            check("R4", beats, 40, "beats for length 40");
            check("R4", beat_valid, 0, "valid after drain");
            check("R7", irq, 1, "irq after drain");
        end

        // R1: reset in the middle of a transfer
        drive(1'b1, 8'h0B, 9, 1'b0);
        @(negedge clk);
        check("R3", beat_valid, 1, "valid after launch");
        drive(1'b0, 8'h00, 9, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1", reg_rdata, 8'h10, "rdata on mid-run reset");
        check("R1", beat_valid, 0, "valid on mid-run reset");
        check("R1", irq, 0, "irq on mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", reg_rdata, 8'h10, "rdata after mid-run reset");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule